// File: doc/BRIEF.md
# Selectable Link Test Pattern Generator

This block feeds a serial transmitter's parallel data path with test words during link self-test. Each clock it emits one word, chosen from four pattern sources. Two are pseudo-random bit sequences: a 7-stage one and a 23-stage one. Two are fixed clock-like patterns: a fast toggle and a slow run of five zeros then five ones. The word width is fixed at elaboration. Widths of 8 or 10 serve a single-width path, and widths of 16 or 20 serve a double-width path.

The pattern is a single serial bit stream that is cut into words. The bit sent first on the line sits in bit 0 of the word. A pseudo-random generator advances by exactly one word of bits per enabled clock, and all of those bits are computed in the same cycle. A fixed pattern keeps its position in its 10-bit cycle from one word to the next, so widths that are not a multiple of ten still give an unbroken stream. A synchronous active-low reset sends every source back to its start. Changing the select while running restarts the newly chosen source from its own start. When enable is low, the block sends zero words and freezes every source.

Top module: `test_pattern_gen`

## Requirements
- R1: One clock after an edge with `rst_n` low, `data_out` is zero. Both shift registers hold all ones, and both fixed-pattern positions are zero.
- R2: Select 0 gives the sequence of x^7 + x^6 + 1. Each new bit is the XOR of stages 7 and 6, and is shifted in at stage 1. Each new bit fills the next word bit upward from bit 0. With WORD_W = 10, the first word after reset is 10'h040.
- R3: Select 1 gives the sequence of x^23 + x^18 + 1. Each new bit is the XOR of stages 23 and 18, and it follows the same bit order as R2.
- R4: Select 2 gives the toggle stream 1,0,1,0,… in line order, so word bit k is 1 exactly when k is even (10'h155 at WORD_W = 10).
- R5: Select 3 gives the stream 0,0,0,0,0,1,1,1,1,1 repeated in line order. Stream bit p is 1 when p mod 10 ≥ 5, and the stream runs on without a break across words. The first word after reset is 10'h3E0 at WORD_W = 10.
- R6: While `enable` is low, `data_out` is zero one clock later and no source advances. When `enable` returns high, each source resumes exactly where it stopped.
- R7: The select encoding is fixed: 0 selects the 7-stage sequence, 1 the 23-stage sequence, 2 the toggle pattern and 3 the run pattern.
- R8: Only the selected source advances. A select value that differs from the previous clock's value restarts the newly selected source from its reset start.
- R9: The output is registered. A word reflects the select and enable sampled at the clock edge that produces it.
- R10: WORD_W is 8, 10, 16 or 20. With WORD_W = 16, the first 7-stage word after reset is 16'h3040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset of all sources |
| enable | input | 1 | High to emit pattern words, low to emit zeros and freeze |
| pat_sel | input | 2 | Pattern select (encoding in R7) |
| data_out | output | WORD_W | Registered test word, bit 0 first on the line |

## Verification
Two instances run side by side from the same stimulus: one 10 bits wide and one 16 bits wide. Only the 16-bit instance steps the run pattern through positions other than zero, so it exposes any break at word borders. Long runs of each pseudo-random sequence separate a wrong tap, a wrong shift direction or a reversed bit order, because each of these flips bits from the second word on. Enable drop-outs followed by resumption show whether a source is frozen or still counting. Select switches, both planned and random, show whether the new source restarts and whether the idle sources stay put.

// File: rtl/tpg_pkg.sv
// Package tpg_pkg
// Shared types and constants for the test pattern generator.
// Fixed patterns are written in line order: bit 0 goes out first.
package tpg_pkg;

    typedef enum logic [1:0] {
        PAT_PRBS7  = 2'd0,
        PAT_PRBS23 = 2'd1,
        PAT_HIGH   = 2'd2,
        PAT_LOW    = 2'd3
    } pat_sel_e;

    // Length of one fixed-pattern cycle, in bits
    localparam int FIX_LEN = 10;

    // Toggle stream 1,0,1,0,... (bit 0 first)
    localparam logic [FIX_LEN-1:0] HIGH_BITS = 10'b01_0101_0101;

    // Run stream: five zeros, then five ones (bit 0 first)
    localparam logic [FIX_LEN-1:0] LOW_BITS  = 10'b11_1110_0000;

endpackage

// File: rtl/tpg_lfsr.sv
// Module tpg_lfsr
// A Fibonacci shift register that yields WORD_W sequence bits per step,
// all computed in one cycle. Each new bit is the XOR of stages TAP_HI and
// TAP_LO (numbered from 1), and it is shifted in at stage 1. The n-th new
// bit goes to word bit n. The seed is all ones.
// Assumes: TAP_HI == STATE_W and TAP_LO < TAP_HI. restart and step are
// synchronous and only matter while rst_n is high.
module tpg_lfsr #(
    parameter int STATE_W = 7,
    parameter int TAP_HI  = 7,
    parameter int TAP_LO  = 6,
    parameter int WORD_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [WORD_W-1:0] word_o
);

    localparam logic [STATE_W-1:0] SEED = '1;

    logic [STATE_W-1:0] state_q;
    logic [STATE_W-1:0] cur_state;
    logic [STATE_W-1:0] walk;

    // Starting point for this cycle: the seed on restart, else the stored state
    assign cur_state = restart ? SEED : state_q;

    // Unroll WORD_W serial shifts to form the word and the next state
    always_comb begin
        walk   = cur_state;
        word_o = '0;
        for (int k = 0; k < WORD_W; k++) begin
            word_o[k] = walk[TAP_HI-1] ^ walk[TAP_LO-1];
            walk      = {walk[STATE_W-2:0], walk[TAP_HI-1] ^ walk[TAP_LO-1]};
        end
    end

    // State register: seed on reset or restart, advance on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (step) begin
            state_q <= walk;
        end else if (restart) begin
            state_q <= SEED;
        end
    end

    AST_SEED_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> state_q == SEED);                                        // R1

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);                                                     // R2

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(state_q));                          // R6

    AST_RESTART_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !step) |=> state_q == SEED);                            // R8

endmodule

// File: rtl/tpg_fixed.sv
// Module tpg_fixed
// Cuts a repeating PAT_LEN-bit pattern (bit 0 first in line order) into
// WORD_W-bit words. It keeps the pattern position between words, so the
// stream has no break when WORD_W is not a multiple of PAT_LEN.
// Assumes: PAT_LEN >= 2. restart and step are synchronous.
module tpg_fixed #(
    parameter int                  WORD_W   = 10,
    parameter int                  PAT_LEN  = 10,
    parameter logic [PAT_LEN-1:0]  PAT_BITS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [WORD_W-1:0] word_o
);

    localparam int              PH_W   = $clog2(PAT_LEN);
    localparam int              STEP   = WORD_W % PAT_LEN;
    localparam logic [PH_W:0]   STEP_V = (PH_W+1)'(STEP);
    localparam logic [PH_W:0]   LEN_V  = (PH_W+1)'(PAT_LEN);
    localparam logic [2*PAT_LEN-1:0] DOUBLED = {PAT_BITS, PAT_BITS};

    logic [PH_W-1:0]      phase_q;
    logic [PH_W-1:0]      cur_phase;
    logic [PH_W:0]        phase_sum;
    logic [PH_W-1:0]      phase_next;
    logic [2*PAT_LEN-1:0] shifted;
    logic [PAT_LEN-1:0]   rotated;

    // Position for this cycle: zero on restart, else the stored position
    assign cur_phase = restart ? '0 : phase_q;

    // Rotate the pattern so that its bit 0 is the bit at the current position
    always_comb begin
        shifted = DOUBLED >> cur_phase;
        rotated = shifted[PAT_LEN-1:0];
    end

    // Spread the rotated pattern over the word, wrapping every PAT_LEN bits
    for (genvar k = 0; k < WORD_W; k++) begin : g_bits
        assign word_o[k] = rotated[k % PAT_LEN];
    end

    // Position after one word: add WORD_W mod PAT_LEN and wrap once
    always_comb begin
        phase_sum = {1'b0, cur_phase} + STEP_V;
        if (phase_sum >= LEN_V) begin
            phase_sum = phase_sum - LEN_V;
        end
        phase_next = phase_sum[PH_W-1:0];
    end

    // Position register: zero on reset or restart, advance on step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= phase_next;
        end else if (restart) begin
            phase_q <= '0;
        end
    end

    AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase_q) < PAT_LEN);                                           // R5

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(phase_q));                          // R6

    AST_PHASE_RESET: assert property (@(posedge clk)
        !rst_n |=> phase_q == '0);                                          // R1

endmodule

// File: rtl/test_pattern_gen.sv
// Module test_pattern_gen
// Top of the link test pattern generator. It holds four pattern sources,
// advances only the selected one, and registers the selected word (zero
// while disabled). A select change restarts the newly selected source.
// Assumes: WORD_W is one of 8, 10, 16, 20. The reset is synchronous and
// active low.
module test_pattern_gen
    import tpg_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        pat_sel,
    output logic [WORD_W-1:0] data_out
);

    localparam int N_SRC = 4;

    // Expected toggle word for the assertion: even bits set
    function automatic logic [WORD_W-1:0] high_word();
        logic [WORD_W-1:0] w;
        for (int k = 0; k < WORD_W; k++) begin
            w[k] = (k % 2 == 0);
        end
        return w;
    endfunction

    localparam logic [WORD_W-1:0] HIGH_WORD = high_word();

    pat_sel_e          sel;
    logic [1:0]        sel_q;
    logic              sel_changed;
    logic [N_SRC-1:0]  src_restart;
    logic [N_SRC-1:0]  src_step;
    logic [WORD_W-1:0] src_word [N_SRC];
    logic [WORD_W-1:0] pick_word;

    assign sel = pat_sel_e'(pat_sel);

    // Remember last select to spot changes
    always_ff @(posedge clk) begin
        sel_q <= pat_sel;
    end

    assign sel_changed = rst_n && (pat_sel != sel_q);

    // One-hot restart and step controls, one bit per source
    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            src_restart[i] = sel_changed && (int'(pat_sel) == i);
            src_step[i]    = enable && (int'(pat_sel) == i);
        end
    end

    tpg_lfsr #(
        .STATE_W (7),
        .TAP_HI  (7),
        .TAP_LO  (6),
        .WORD_W  (WORD_W)
    ) prbs7_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (src_restart[PAT_PRBS7]),
        .step    (src_step[PAT_PRBS7]),
        .word_o  (src_word[PAT_PRBS7])
    );

    tpg_lfsr #(
        .STATE_W (23),
        .TAP_HI  (23),
        .TAP_LO  (18),
        .WORD_W  (WORD_W)
    ) prbs23_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (src_restart[PAT_PRBS23]),
        .step    (src_step[PAT_PRBS23]),
        .word_o  (src_word[PAT_PRBS23])
    );

    tpg_fixed #(
        .WORD_W   (WORD_W),
        .PAT_LEN  (FIX_LEN),
        .PAT_BITS (HIGH_BITS)
    ) high_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (src_restart[PAT_HIGH]),
        .step    (src_step[PAT_HIGH]),
        .word_o  (src_word[PAT_HIGH])
    );

    tpg_fixed #(
        .WORD_W   (WORD_W),
        .PAT_LEN  (FIX_LEN),
        .PAT_BITS (LOW_BITS)
    ) low_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (src_restart[PAT_LOW]),
        .step    (src_step[PAT_LOW]),
        .word_o  (src_word[PAT_LOW])
    );

    // Choose the selected source's word
    always_comb begin
        case (sel)
            PAT_PRBS7:  pick_word = src_word[PAT_PRBS7];
            PAT_PRBS23: pick_word = src_word[PAT_PRBS23];
            PAT_HIGH:   pick_word = src_word[PAT_HIGH];
            default:    pick_word = src_word[PAT_LOW];
        endcase
    end

    // Output register: zero on reset or when disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out <= '0;
        end else if (enable) begin
            data_out <= pick_word;
        end else begin
            data_out <= '0;
        end
    end

    initial begin
        AST_WIDTH_LEGAL: assert (WORD_W == 8 || WORD_W == 10 ||
                                 WORD_W == 16 || WORD_W == 20);            // R10
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> data_out == '0);                                         // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> data_out == '0);                                        // R6

    AST_HIGH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && pat_sel == 2'd2) |=> data_out == HIGH_WORD);             // R4

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_step));                                                // R8

endmodule

// File: tb/test_pattern_gen_tb_top.sv
// Bench for test_pattern_gen. A 10-bit and a 16-bit instance get the same
// stimulus. A bit-serial reference model computes each expected word, and
// both outputs are compared on every clock.
module test_pattern_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WID [2] = '{10, 16};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  pat_sel = 2'd0;
    logic [9:0]  out_a;
    logic [15:0] out_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state
    int unsigned m7   [2];
    int unsigned m23  [2];
    int          ph_hi[2];
    int          ph_lo[2];
    logic [1:0]  msel [2];
    logic [31:0] mexp [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    test_pattern_gen #(.WORD_W(10)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .pat_sel  (pat_sel),
        .data_out (out_a)
    );

    test_pattern_gen #(.WORD_W(16)) dut_w16_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .pat_sel  (pat_sel),
        .data_out (out_b)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Restart one source of instance i at its starting point (R1, R8)
    task automatic model_restart(input int i, input logic [1:0] s);
        case (s)
            2'd0: m7[i]    = 32'h7F;
            2'd1: m23[i]   = 32'h7F_FFFF;
            2'd2: ph_hi[i] = 0;
            default: ph_lo[i] = 0;
        endcase
    endtask

    // Model one clock edge, using the inputs that stand at that edge
    task automatic model_edge();
        for (int i = 0; i < 2; i++) begin
            logic [31:0] w;
            int unsigned nb;
            w = '0;
            if (!rst_n) begin
                m7[i] = 32'h7F; m23[i] = 32'h7F_FFFF;
                ph_hi[i] = 0; ph_lo[i] = 0;
                msel[i] = pat_sel;
            end else begin
                if (pat_sel != msel[i]) model_restart(i, pat_sel);
                msel[i] = pat_sel;
                if (enable) begin
                    for (int k = 0; k < WID[i]; k++) begin
                        case (pat_sel)
                            2'd0: begin
                                nb = ((m7[i] >> 6) ^ (m7[i] >> 5)) & 1;
                                m7[i] = ((m7[i] << 1) | nb) & 32'h7F;
                                w[k] = nb[0];
                            end
                            2'd1: begin
                                nb = ((m23[i] >> 22) ^ (m23[i] >> 17)) & 1;
                                m23[i] = ((m23[i] << 1) | nb) & 32'h7F_FFFF;
                                w[k] = nb[0];
                            end
                            2'd2: w[k] = ((ph_hi[i] + k) % 2) == 0;
                            default: w[k] = ((ph_lo[i] + k) % 10) >= 5;
                        endcase
                    end
                    if (pat_sel == 2'd2) ph_hi[i] = (ph_hi[i] + WID[i]) % 2;
                    if (pat_sel == 2'd3) ph_lo[i] = (ph_lo[i] + WID[i]) % 10;
                end
            end
            mexp[i] = w;
        end
    endtask

    // One clock: drive at the falling edge, model at the rising edge,
    // compare at the next falling edge
    task automatic cyc(input logic r, input logic [1:0] s, input logic e);
        string tag;
        rst_n = r; pat_sel = s; enable = e;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        if (!r)      tag = "R1";
        else if (!e) tag = "R6";
        else case (s)
            2'd0: tag = "R2";
            2'd1: tag = "R3";
            2'd2: tag = "R4";
            default: tag = "R5";
        endcase
        check(tag, {22'b0, out_a}, mexp[0]);
        check({tag, "/R10"}, {16'b0, out_b}, mexp[1]);
    endtask

    initial begin
        @(negedge clk);
        // Reset: output zero (R1)
        repeat (3) cyc(1'b0, 2'd0, 1'b0);
        check("R1 reset zero", {22'b0, out_a}, 32'h0);
        // First 7-stage words, fixed values (R2, R9, R10)
        cyc(1'b1, 2'd0, 1'b1);
        check("R2/R9 first word", {22'b0, out_a}, 32'h040);
        check("R10 first word w16", {16'b0, out_b}, 32'h3040);
        repeat (40) cyc(1'b1, 2'd0, 1'b1);
        // Enable drop and resume (R6)
        repeat (5) cyc(1'b1, 2'd0, 1'b0);
        check("R6 idle zero", {22'b0, out_a}, 32'h0);
        repeat (10) cyc(1'b1, 2'd0, 1'b1);
        // 23-stage sequence (R3, R8)
        repeat (200) cyc(1'b1, 2'd1, 1'b1);
        // Toggle pattern (R4, R7)
        cyc(1'b1, 2'd2, 1'b1);
        check("R4/R7 toggle word", {22'b0, out_a}, 32'h155);
        repeat (10) cyc(1'b1, 2'd2, 1'b1);
        // Run pattern, unbroken across 16-bit words (R5)
        cyc(1'b1, 2'd3, 1'b1);
        check("R5/R7 run word", {22'b0, out_a}, 32'h3E0);
        repeat (20) cyc(1'b1, 2'd3, 1'b1);
        repeat (3) cyc(1'b1, 2'd3, 1'b0);
        repeat (7) cyc(1'b1, 2'd3, 1'b1);
        // Back to select 0: restart from seed (R8)
        cyc(1'b1, 2'd0, 1'b1);
        check("R8 restart word", {22'b0, out_a}, 32'h040);
        // Change select while disabled, then resume (R8, R6)
        repeat (4) cyc(1'b1, 2'd0, 1'b1);
        cyc(1'b1, 2'd1, 1'b0);
        cyc(1'b1, 2'd0, 1'b0);
        cyc(1'b1, 2'd0, 1'b1);
        check("R8 restart after idle", {22'b0, out_a}, 32'h040);
        // Reset in the middle of a run (R1)
        repeat (15) cyc(1'b1, 2'd1, 1'b1);
        cyc(1'b0, 2'd1, 1'b1);
        check("R1 mid-run reset", {22'b0, out_a}, 32'h0);
        repeat (30) cyc(1'b1, 2'd1, 1'b1);
        // Random mix of selects and enable (R6, R8)
        for (int n = 0; n < 600; n++) begin
            logic [1:0] s;
            logic e;
            s = 2'($urandom_range(0, 3));
            e = ($urandom_range(0, 3) != 0);
            repeat ($urandom_range(1, 6)) cyc(1'b1, s, e);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule